// File: doc/BRIEF.md
# Soft-Start and Power-Good Sequencer

This block brings a multiphase buck regulator from power-on up to regulation on a fixed timeline counted in switching cycles. It watches two comparator flags that together give the supply monitor its hysteresis. One flag reports that the supply is above the turn-on level and the other that it is below the turn-off level. Once the supply is good, the block holds the phase outputs in high impedance for a short hold-off. It then clamps them low while the analog loop settles. After that it enables a duty ramp and raises the error-amplifier reference code linearly from zero to the programmed target. The power-good pull-down is released only on the final counted cycle.

Every count comes from a switching-cycle tick input. A supply drop or an overcurrent at any point after launch restarts the timeline from the beginning and clears the single cycle counter. The analog comparators, the reference DAC and the PWM generator sit outside the block and consume its mode, code and enable outputs.

Top module: `soft_start_seq`

## Requirements
- R1: Under reset, and after it until a launch, `pwm_mode` is 2'b00 (high impedance), `ref_code` is 0, `duty_ramp_en` is 0 and `pgood_pull_dn` is 1 (pulling power-good low). `pwm_mode` never takes the value 2'b11.
- R2: A launch takes place on the clock where `vcc_above_on` is 1 and `vcc_below_off` is 0. While both flags are 0, the block keeps its current course: an idle block stays idle and a running sequence continues.
- R3: For the first TRI_CYC ticks after a launch or restart, `pwm_mode` stays 2'b00 and `ref_code` stays 0. The clock after tick TRI_CYC shows 2'b01.
- R4: For the next LOW_CYC ticks, `pwm_mode` is 2'b01 (forced low), `ref_code` is 0 and power-good stays pulled low.
- R5: After those ticks, `pwm_mode` is 2'b10 (active) and `duty_ramp_en` is 1. After N ticks in this phase, `ref_code` equals floor(target·N / (GOOD_CYC − TRI_CYC − LOW_CYC)).
- R6: `pgood_pull_dn` falls in the clock after tick GOOD_CYC, counted from launch, and not earlier. While it is 0, `pwm_mode` is 2'b10, `duty_ramp_en` is 0 and `ref_code` equals `ref_target`.
- R7: With `vcc_below_off` at 1 in any state, the next clock shows `pwm_mode` 2'b00, `ref_code` 0 and power-good pulled low. A new launch then needs R2.
- R8: With `ovc_flag` at 1 in any running state, including regulation, the next clock shows `pwm_mode` 2'b00 and power-good pulled low. The timeline then restarts from tick zero without waiting for the supply flags.
- R9: Ticks received while idle have no effect on the later timeline.
- R10: Once in regulation, further ticks change nothing. Power-good stays released until a drop or an overcurrent occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_above_on | input | 1 | Supply is above the turn-on threshold |
| vcc_below_off | input | 1 | Supply is below the turn-off threshold |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| ovc_flag | input | 1 | Overcurrent detected |
| ref_target | input | REF_W | Programmed reference code |
| pwm_mode | output | 2 | 00 high impedance, 01 forced low, 10 active |
| ref_code | output | REF_W | Reference code sent to the DAC |
| duty_ramp_en | output | 1 | Duty ramp in progress |
| pgood_pull_dn | output | 1 | 1 pulls the open-drain power-good line low |

## Verification
The bench builds two instances with short timings: TRI_CYC=4, LOW_CYC=6 and GOOD_CYC=64, which gives a 54-tick ramp. With these values every phase boundary, and the release of power-good, comes within a few hundred clocks. One instance has an 8-bit reference, so targets above the span force several code steps per tick through the quotient path. The other has a 5-bit reference, which keeps every target below the span and selects the single-step accumulator variant. Both instances are checked against a behavioural phase-and-tick model on every clock, through drops, restarts and zero and full-scale targets.

// File: rtl/ss_seq_pkg.sv
// Shared types of the soft-start sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package ss_seq_pkg;

    // Drive condition requested from the phase output stages.
    typedef enum logic [1:0] {
        PWM_TRISTATE  = 2'b00,
        PWM_FORCE_LOW = 2'b01,
        PWM_ACTIVE    = 2'b10
    } pwm_mode_e;

    // Sequencer phases, from idle to regulation.
    typedef enum logic [2:0] {
        PH_POR      = 3'd0,
        PH_HOLD_OFF = 3'd1,
        PH_CLAMP    = 3'd2,
        PH_RAMP     = 3'd3,
        PH_REG      = 3'd4
    } phase_e;

endpackage

// File: rtl/ss_tick_counter.sv
// Single switching-cycle counter shared by every phase of the start-up.
// Reports when the count sits on the last tick of each phase.
// Assumes: HOLD_END < CLAMP_END < RAMP_END < 2**CNT_W.
module ss_tick_counter #(
    parameter int CNT_W     = 11,
    parameter int HOLD_END  = 31,
    parameter int CLAMP_END = 181,
    parameter int RAMP_END  = 2047
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic hold_done,
    output logic clamp_done,
    output logic ramp_done
);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_END);
    localparam logic [CNT_W-1:0] CLAMP_LAST = CNT_W'(CLAMP_END);
    localparam logic [CNT_W-1:0] RAMP_LAST  = CNT_W'(RAMP_END);

    logic [CNT_W-1:0] cnt_q;

    // Count accepted ticks; any restart returns the count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Flag the last tick of each phase.
    assign hold_done  = (cnt_q == HOLD_LAST);
    assign clamp_done = (cnt_q == CLAMP_LAST);
    assign ramp_done  = (cnt_q == RAMP_LAST);
endmodule

// File: rtl/ss_ref_ramp.sv
// Linear reference ramp: after N steps the level is floor(target*N/SPAN).
// It adds the quotient target/SPAN on every step and carries the
// remainder through an accumulator. When every target fits below SPAN,
// the divider is left out. In regulation the target is passed straight
// through.
// Assumes: the target is held steady while the ramp runs.
module ss_ref_ramp #(
    parameter int REF_W = 8,
    parameter int SPAN  = 1866
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             hold_target,
    input  logic [REF_W-1:0] target,
    output logic [REF_W-1:0] ref_code
);
    localparam int ACC_W  = $clog2(SPAN) + 1;
    localparam int WIDE_W = REF_W + ACC_W;
    localparam bit ONE_STEP = ((1 << REF_W) - 1) < SPAN;
    localparam logic [WIDE_W-1:0] SPAN_WIDE = WIDE_W'(SPAN);
    localparam logic [ACC_W:0]    SPAN_ACC  = (ACC_W + 1)'(SPAN);

    logic [REF_W-1:0] whole;
    logic [ACC_W-1:0] rem;
    logic [ACC_W-1:0] acc_q, acc_d;
    logic [REF_W-1:0] lvl_q, lvl_d;
    logic [ACC_W:0]   acc_sum;
    logic             carry;

    generate
        if (ONE_STEP) begin : g_single
            // The target never reaches SPAN: at most one code step per tick.
            assign whole = '0;
            assign rem   = ACC_W'(target);
        end else begin : g_div
            // Split the target into whole steps and a fractional remainder.
            assign whole = REF_W'(WIDE_W'(target) / SPAN_WIDE);
            assign rem   = ACC_W'(WIDE_W'(target) % SPAN_WIDE);
        end
    endgenerate

    // Next accumulator and level for one ramp step.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, rem};
        carry   = (acc_sum >= SPAN_ACC);
        acc_d   = carry ? ACC_W'(acc_sum - SPAN_ACC) : ACC_W'(acc_sum);
        lvl_d   = lvl_q + whole + REF_W'(carry);
    end

    // Hold the ramp state; clear it on every restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            lvl_q <= '0;
        end else if (step) begin
            acc_q <= acc_d;
            lvl_q <= lvl_d;
        end
    end

    assign ref_code = hold_target ? target : lvl_q;
endmodule

// File: rtl/ss_phase_fsm.sv
// Phase sequencer: idle, hold-off, clamp, ramp, regulation.
// Decides launch, drop and restart, and decodes the drive outputs.
// Assumes: the counter flags come from ss_tick_counter on the same clock.
module ss_phase_fsm
    import ss_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      above_on,
    input  logic      below_off,
    input  logic      tick,
    input  logic      ovc,
    input  logic      hold_done,
    input  logic      clamp_done,
    input  logic      ramp_done,
    output logic      cnt_clr,
    output logic      cnt_adv,
    output logic      ramp_step,
    output logic      in_reg,
    output pwm_mode_e mode,
    output logic      ramp_en,
    output logic      pull_dn
);
    phase_e ph_q, ph_d;
    logic   running, drop, restart, launch;

    // Classify the current inputs against the present phase.
    assign running   = (ph_q == PH_HOLD_OFF) || (ph_q == PH_CLAMP) || (ph_q == PH_RAMP);
    assign drop      = (ph_q != PH_POR) && below_off;
    assign restart   = (ph_q != PH_POR) && !below_off && ovc;
    assign launch    = (ph_q == PH_POR) && above_on && !below_off;
    assign cnt_clr   = (ph_q == PH_POR) || drop || restart;
    assign cnt_adv   = tick && running && !drop && !restart;
    assign ramp_step = cnt_adv && (ph_q == PH_RAMP);
    assign in_reg    = (ph_q == PH_REG);

    // Choose the next phase; faults take priority over tick progress.
    always_comb begin
        ph_d = ph_q;
        if (drop) begin
            ph_d = PH_POR;
        end else if (restart) begin
            ph_d = PH_HOLD_OFF;
        end else begin
            case (ph_q)
                PH_POR:      if (launch)                  ph_d = PH_HOLD_OFF;
                PH_HOLD_OFF: if (cnt_adv && hold_done)  ph_d = PH_CLAMP;
                PH_CLAMP:    if (cnt_adv && clamp_done) ph_d = PH_RAMP;
                PH_RAMP:     if (cnt_adv && ramp_done)  ph_d = PH_REG;
                default:     ph_d = ph_q;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= PH_POR;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Decode the drive outputs from the registered phase.
    always_comb begin
        mode    = PWM_TRISTATE;
        ramp_en = 1'b0;
        pull_dn = 1'b1;
        case (ph_q)
            PH_CLAMP: mode = PWM_FORCE_LOW;
            PH_RAMP: begin
                mode    = PWM_ACTIVE;
                ramp_en = 1'b1;
            end
            PH_REG: begin
                mode    = PWM_ACTIVE;
                pull_dn = 1'b0;
            end
            default: mode = PWM_TRISTATE;
        endcase
    end
endmodule

// File: rtl/soft_start_seq.sv
// Soft-start and power-good sequencer for a multiphase regulator.
// Ties the phase sequencer, the shared cycle counter and the reference
// ramp together.
// Assumes: cyc_tick is a single-clock pulse per switching cycle, the
// supply flags are already synchronised, and TRI_CYC+LOW_CYC < GOOD_CYC.
module soft_start_seq #(
    parameter int TRI_CYC  = 32,
    parameter int LOW_CYC  = 150,
    parameter int GOOD_CYC = 2048,
    parameter int REF_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vcc_above_on,
    input  logic             vcc_below_off,
    input  logic             cyc_tick,
    input  logic             ovc_flag,
    input  logic [REF_W-1:0] ref_target,
    output logic [1:0]       pwm_mode,
    output logic [REF_W-1:0] ref_code,
    output logic             duty_ramp_en,
    output logic             pgood_pull_dn
);
    import ss_seq_pkg::*;

    localparam int CNT_W = $clog2(GOOD_CYC);
    localparam int SPAN  = GOOD_CYC - TRI_CYC - LOW_CYC;

    logic      cnt_clr, cnt_adv, ramp_step, in_reg;
    logic      hold_done, clamp_done, ramp_done;
    pwm_mode_e mode;

    ss_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_on   (vcc_above_on),
        .below_off  (vcc_below_off),
        .tick       (cyc_tick),
        .ovc        (ovc_flag),
        .hold_done  (hold_done),
        .clamp_done (clamp_done),
        .ramp_done  (ramp_done),
        .cnt_clr    (cnt_clr),
        .cnt_adv    (cnt_adv),
        .ramp_step  (ramp_step),
        .in_reg     (in_reg),
        .mode       (mode),
        .ramp_en    (duty_ramp_en),
        .pull_dn    (pgood_pull_dn)
    );

    ss_tick_counter #(
        .CNT_W     (CNT_W),
        .HOLD_END  (TRI_CYC - 1),
        .CLAMP_END (TRI_CYC + LOW_CYC - 1),
        .RAMP_END  (GOOD_CYC - 1)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .adv        (cnt_adv),
        .hold_done  (hold_done),
        .clamp_done (clamp_done),
        .ramp_done  (ramp_done)
    );

    ss_ref_ramp #(
        .REF_W (REF_W),
        .SPAN  (SPAN)
    ) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (cnt_clr),
        .step        (ramp_step),
        .hold_target (in_reg),
        .target      (ref_target),
        .ref_code    (ref_code)
    );

    assign pwm_mode = mode;
endmodule

// File: rtl/soft_start_seq_chk.sv
// Property checker for soft_start_seq, attached by bind below.
// Assumes: the target is held steady over a ramp.
module soft_start_seq_chk
    import ss_seq_pkg::*;
#(
    parameter int LOW_CYC = 150,
    parameter int REF_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vcc_below_off,
    input logic             cyc_tick,
    input logic             ovc_flag,
    input logic [REF_W-1:0] ref_target,
    input logic [1:0]       pwm_mode,
    input logic [REF_W-1:0] ref_code,
    input logic             duty_ramp_en,
    input logic             pgood_pull_dn
);
    int clamp_ticks;

    // Count the ticks seen while the outputs are clamped low.
    always_ff @(posedge clk) begin
        if (!rst_n || pwm_mode != PWM_FORCE_LOW) begin
            clamp_ticks <= 0;
        end else if (cyc_tick) begin
            clamp_ticks <= clamp_ticks + 1;
        end
    end

    AST_LEGAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_mode != 2'b11); // R1
    AST_NO_SKIP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == PWM_ACTIVE && $past(pwm_mode) != PWM_ACTIVE)
        |-> $past(pwm_mode) == PWM_FORCE_LOW); // R3
    AST_CLAMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_mode == PWM_FORCE_LOW |-> ref_code == '0 && pgood_pull_dn && !duty_ramp_en); // R4
    AST_CLAMP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode == PWM_ACTIVE && $past(pwm_mode) == PWM_FORCE_LOW)
        |-> clamp_ticks == LOW_CYC); // R4
    AST_RAMP_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        duty_ramp_en |-> pwm_mode == PWM_ACTIVE && pgood_pull_dn); // R5
    AST_RAMP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_ramp_en && $past(duty_ramp_en)) |-> ref_code >= $past(ref_code)); // R5
    AST_GOOD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !pgood_pull_dn |-> pwm_mode == PWM_ACTIVE && !duty_ramp_en && ref_code == ref_target); // R6
    AST_UVLO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_below_off |=> pwm_mode == PWM_TRISTATE && pgood_pull_dn && ref_code == '0); // R7
    AST_OVC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ovc_flag |=> pwm_mode == PWM_TRISTATE && pgood_pull_dn && ref_code == '0); // R8
    AST_REG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pgood_pull_dn && !vcc_below_off && !ovc_flag) |=> !pgood_pull_dn); // R10
endmodule

bind soft_start_seq soft_start_seq_chk #(
    .LOW_CYC (LOW_CYC),
    .REF_W   (REF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_below_off (vcc_below_off),
    .cyc_tick      (cyc_tick),
    .ovc_flag      (ovc_flag),
    .ref_target    (ref_target),
    .pwm_mode      (pwm_mode),
    .ref_code      (ref_code),
    .duty_ramp_en  (duty_ramp_en),
    .pgood_pull_dn (pgood_pull_dn)
);

// File: tb/soft_start_seq_bench.sv
`timescale 1ns/1ps
module soft_start_seq_bench;
    localparam int TRI  = 4;
    localparam int LOW  = 6;
    localparam int GOOD = 64;
    localparam int SPAN = GOOD - TRI - LOW;
    localparam int RW   = 8;
    localparam int RWN  = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, hi, lo, tk, oc;
    logic [RW-1:0]  tgt;
    logic [RWN-1:0] tgtn;
    logic [1:0]     mode_w, mode_n;
    logic [RW-1:0]  ref_w;
    logic [RWN-1:0] ref_n;
    logic           ramp_w, ramp_n, pull_w, pull_n;

    soft_start_seq #(.TRI_CYC(TRI), .LOW_CYC(LOW), .GOOD_CYC(GOOD), .REF_W(RW)) u_soft_start_seq (
        .clk(clk), .rst_n(rst_n), .vcc_above_on(hi), .vcc_below_off(lo), .cyc_tick(tk),
        .ovc_flag(oc), .ref_target(tgt), .pwm_mode(mode_w), .ref_code(ref_w),
        .duty_ramp_en(ramp_w), .pgood_pull_dn(pull_w));

    soft_start_seq #(.TRI_CYC(TRI), .LOW_CYC(LOW), .GOOD_CYC(GOOD), .REF_W(RWN)) u_soft_start_seq_nr (
        .clk(clk), .rst_n(rst_n), .vcc_above_on(hi), .vcc_below_off(lo), .cyc_tick(tk),
        .ovc_flag(oc), .ref_target(tgtn), .pwm_mode(mode_n), .ref_code(ref_n),
        .duty_ramp_en(ramp_n), .pgood_pull_dn(pull_n));

    int n_chk = 0;
    int n_fail = 0;
    int ph = 0;   // 0 idle, 1 hold-off, 2 clamp, 3 ramp, 4 regulation
    int tcnt = 0; // ticks since launch

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase and tick count since launch.
    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; tcnt = 0;
        end else if (ph == 0) begin
            if (hi && !lo) begin ph = 1; tcnt = 0; end
        end else if (lo) begin
            ph = 0; tcnt = 0;
        end else if (oc) begin
            ph = 1; tcnt = 0;
        end else if (tk && ph != 4) begin
            tcnt++;
            if (ph == 1 && tcnt == TRI) ph = 2;
            else if (ph == 2 && tcnt == TRI + LOW) ph = 3;
            else if (ph == 3 && tcnt == GOOD) ph = 4;
        end
    end

    function automatic int exp_ref(input int t);
        if (ph == 3) return (t * (tcnt - TRI - LOW)) / SPAN;
        if (ph == 4) return t;
        return 0;
    endfunction

    task automatic compare_all();
        string req;
        int em;
        case (ph)
            0: req = "R1";
            1: req = "R3";
            2: req = "R4";
            3: req = "R5";
            default: req = "R6";
        endcase
        em = (ph <= 1) ? 0 : (ph == 2) ? 1 : 2;
        check(int'(mode_w) == em, req, "pwm_mode", int'(mode_w), em);
        check(int'(mode_n) == em, req, "pwm_mode narrow", int'(mode_n), em);
        check(int'(ref_w) == exp_ref(int'(tgt)), req, "ref_code", int'(ref_w), exp_ref(int'(tgt)));
        check(int'(ref_n) == exp_ref(int'(tgtn)), req, "ref_code narrow", int'(ref_n), exp_ref(int'(tgtn)));
        check(ramp_w == (ph == 3), req, "duty_ramp_en", int'(ramp_w), int'(ph == 3));
        check(ramp_n == (ph == 3), req, "duty_ramp_en narrow", int'(ramp_n), int'(ph == 3));
        check(pull_w == (ph != 4), req, "pgood_pull_dn", int'(pull_w), int'(ph != 4));
        check(pull_n == (ph != 4), req, "pgood_pull_dn narrow", int'(pull_n), int'(ph != 4));
    endtask

    // Drive one clock worth of inputs, then compare after the edge.
    task automatic step(input bit h, input bit l, input bit t, input bit o);
        hi = h; lo = l; tk = t; oc = o;
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(input int n, input bit h, input bit l, input bit fast);
        for (int i = 0; i < n; i++) begin
            step(h, l, 1'b1, 1'b0);
            if (!fast) step(h, l, 1'b0, 1'b0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; hi = 0; lo = 0; tk = 0; oc = 0;
        tgt = 8'd200; tgtn = 5'd23;
        repeat (3) @(negedge clk);
        compare_all();
        rst_n = 1'b1;
        step(0, 0, 0, 0);
        // R1: idle outputs after reset
        check(mode_w == 2'b00, "R1", "mode idle", int'(mode_w), 0);
        check(pull_w == 1'b1, "R1", "pull idle", int'(pull_w), 1);
        check(ref_w == '0, "R1", "ref idle", int'(ref_w), 0);

        // R9: ticks while idle, below and between thresholds
        ticks(10, 0, 1, 0);
        ticks(5, 0, 0, 1);
        check(mode_w == 2'b00 && pull_w, "R9", "idle after ticks", int'(mode_w), 0);

        // Launch, then run with both flags low (R2)
        step(1, 0, 0, 0);
        ticks(TRI - 1, 0, 0, 0);
        check(mode_w == 2'b00, "R3", "still tristate", int'(mode_w), 0);
        ticks(1, 0, 0, 0);
        check(mode_w == 2'b01, "R4", "clamp begins", int'(mode_w), 1);
        ticks(LOW - 1, 0, 0, 0);
        check(mode_w == 2'b01, "R4", "clamp holds", int'(mode_w), 1);
        ticks(1, 0, 0, 0);
        check(mode_w == 2'b10 && ramp_w, "R5", "ramp begins", int'(mode_w), 2);
        ticks(SPAN - 1, 0, 0, 1);
        check(pull_w == 1'b1, "R6", "no early power-good", int'(pull_w), 1);
        ticks(1, 0, 0, 1);
        check(pull_w == 1'b0, "R6", "power-good at final tick", int'(pull_w), 0);
        check(ref_w == tgt, "R6", "ref at target", int'(ref_w), int'(tgt));
        check(pull_w == 1'b0, "R2", "sequence ran with flags low", int'(pull_w), 0);

        // R10: ticks in regulation change nothing
        ticks(20, 0, 0, 1);
        check(pull_w == 1'b0 && ref_w == tgt && mode_w == 2'b10, "R10", "regulation steady", int'(pull_w), 0);

        // R7: supply drop from regulation
        step(0, 1, 0, 0);
        check(mode_w == 2'b00 && pull_w && ref_w == '0, "R7", "drop to idle", int'(mode_w), 0);
        ticks(4, 0, 0, 0);
        check(mode_w == 2'b00, "R7", "needs relaunch", int'(mode_w), 0);
        step(1, 0, 0, 0);

        // R8: overcurrent with a tick in the middle of the ramp
        ticks(TRI + LOW + 7, 0, 0, 1);
        step(0, 0, 1, 1);
        check(mode_w == 2'b00 && pull_w && ref_w == '0, "R8", "restart on overcurrent", int'(mode_w), 0);
        ticks(GOOD - 1, 0, 0, 1);
        check(pull_w == 1'b1, "R8", "full timeline after restart", int'(pull_w), 1);
        ticks(1, 0, 0, 1);
        check(pull_w == 1'b0, "R8", "power-good after restart", int'(pull_w), 0);
        step(0, 0, 0, 1);
        check(pull_w == 1'b1 && mode_w == 2'b00, "R8", "overcurrent in regulation", int'(pull_w), 1);

        // R7: drop during the clamp, then new targets
        ticks(TRI + 2, 0, 0, 0);
        step(0, 1, 0, 0);
        check(mode_w == 2'b00 && pull_w, "R7", "drop in clamp", int'(mode_w), 0);
        tgt = 8'd37; tgtn = 5'd31;
        ticks(3, 0, 0, 0);
        step(1, 0, 0, 0);
        ticks(GOOD, 0, 0, 0);
        check(pull_w == 1'b0 && ref_w == 8'd37 && ref_n == 5'd31, "R5", "small and full-scale targets", int'(ref_w), 37);

        // R6: zero target
        step(0, 1, 0, 0);
        tgt = '0; tgtn = '0;
        step(1, 0, 0, 0);
        ticks(GOOD, 1, 0, 1);
        check(pull_w == 1'b0 && ref_w == '0, "R6", "zero target", int'(ref_w), 0);

        summary();
        $finish;
    end
endmodule